// File: doc/BRIEF.md
# UART Receive Interrupt Generator

This block produces the receive-side interrupt conditions of a 16550-style UART with a 16-entry receive FIFO. It watches two strobes: one marks a character entering the FIFO from the serial shifter, and the other marks a CPU read of the FIFO. It also watches the FIFO occupancy, a programmable trigger level, a line-status error flag and a one-cycle baud-rate enable. The outputs are the data-ready bit, three interrupt lines and one interrupt identification code. The code gives the highest-priority receive condition that is pending.

A character-timeout timer counts baud enables, and one character time is the frame length in bits times 16 enables. The timer is cleared by every received character and by every CPU read. When the FIFO holds data and four character times pass with neither event, the timeout interrupt is raised. The timeout then stays pending until the CPU reads the FIFO.

The serial shifter, the FIFO storage and the baud generator sit outside the block. The block sees them only as the strobes, the count and the enable described above.

Top module: `uart_rx_irq`

## Requirements
- R1: `rda_irq` is high whenever `count >= trig_lvl`, `count` is nonzero and the block is enabled (see R9). It falls in the same cycle that `count` drops below `trig_lvl`.
- R2: `data_ready` goes to 1 on the clock edge where `wr_stb` is high. It stays 1 until an edge where `count` is 0 and `wr_stb` is low, and on that edge it clears.
- R3: `ls_irq` is high whenever `ls_err` is set, `ls_ie` is 1 and `fifo_en` is 1.
- R4: `irq_code` follows a fixed priority order:
  - 4'h6 when `ls_irq` is high;
  - otherwise 4'hC when `timeout_irq` is high;
  - otherwise 4'h4 when `rda_irq` is high;
  - otherwise 4'h1, meaning no interrupt.
- R5: With `count` nonzero, the timeout becomes pending on the clock edge that carries the 4*16*B-th baud enable after the last `wr_stb` or `rd_stb` edge. B is the frame length in bits.
- R6: B = 7 + `data_bits` + `parity_en` + `two_stop`.
  - `data_bits` codes 0..3 select 5..8 data bits.
  - `two_stop`=1 adds the second stop bit.
  - B therefore ranges from 7 to 12.
- R7: A pending timeout is cleared on the edge of a `rd_stb`, and the timer restarts from zero there.
- R8: While no timeout is pending, `wr_stb` or `rd_stb` restarts the timer. A `wr_stb` does not clear a timeout that is already pending.
- R9: `rda_irq` and `timeout_irq` are forced low unless both `fifo_en` and `rx_ie` are 1. `ls_irq` is forced low unless `fifo_en` is 1.
- R10: Reset (`rst_n` low) or `fifo_clr` high clears `data_ready`, the pending timeout and the timer on the next edge.
- R11: The timer advances only on cycles with `baud_en` high, so the timeout delay scales with the baud rate.
- R12: On any edge where `count` is 0, the pending timeout is cleared and no timeout can become pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_clr | input | 1 | Receive FIFO reset pulse |
| fifo_en | input | 1 | FIFO mode enable |
| rx_ie | input | 1 | Received-data and timeout interrupt enable |
| ls_ie | input | 1 | Line status interrupt enable |
| wr_stb | input | 1 | Character written into the FIFO |
| rd_stb | input | 1 | CPU read of the FIFO |
| count | input | 5 | FIFO occupancy, 0..16 |
| trig_lvl | input | 5 | Trigger level, 1..16 |
| ls_err | input | 1 | Line status error flag |
| baud_en | input | 1 | One 16x baud clock enable |
| data_bits | input | 2 | Data length code, 0..3 gives 5..8 bits |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Two stop bits |
| data_ready | output | 1 | Data-ready status bit |
| rda_irq | output | 1 | Received-data-available interrupt |
| timeout_irq | output | 1 | Character timeout interrupt |
| ls_irq | output | 1 | Line status interrupt |
| irq_code | output | 4 | Highest-priority receive interrupt code |

## Verification
A vector table pairs counts and trigger levels at, below and above the threshold with error flags and enables. This separates the threshold compare from the enable gating and from the three-way priority.

The timeout is exercised separately:
- with the shortest frame of 7 bits and with the longest frame of 12 bits, sampled one cycle before and on the expected edge;
- with baud enables every second cycle, to show the timer counts enables rather than clocks;
- with reads and writes inserted part-way, to tell a timer restart apart from a pending clear.

// File: rtl/uart_rx_irq.sv
module uart_rx_irq #(
  parameter int DEPTH    = 16,
  parameter int OVS      = 16,
  parameter int TO_CHARS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_clr,
  input  logic                       fifo_en,
  input  logic                       rx_ie,
  input  logic                       ls_ie,
  input  logic                       wr_stb,
  input  logic                       rd_stb,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [$clog2(DEPTH+1)-1:0] trig_lvl,
  input  logic                       ls_err,
  input  logic                       baud_en,
  input  logic [1:0]                 data_bits,
  input  logic                       parity_en,
  input  logic                       two_stop,
  output logic                       data_ready,
  output logic                       rda_irq,
  output logic                       timeout_irq,
  output logic                       ls_irq,
  output logic [3:0]                 irq_code
);
  localparam int MAXBITS = 12;
  localparam int TW = $clog2(TO_CHARS * OVS * MAXBITS + 1);

  logic [3:0]    char_bits;
  logic [TW-1:0] limit;
  logic [TW-1:0] tmr;
  logic          to_q;
  logic          dr_q;
  logic          has_data;
  logic          rx_on;

  assign char_bits = 4'd7 + {2'b00, data_bits} + {3'b000, parity_en} + {3'b000, two_stop};
  assign limit     = TW'(char_bits) * TW'(TO_CHARS * OVS);
  assign has_data  = count != '0;
  assign rx_on     = fifo_en && rx_ie;

  always_ff @(posedge clk) begin
    if (!rst_n || fifo_clr) begin
      tmr  <= '0;
      to_q <= 1'b0;
    end else if (rd_stb) begin
      tmr  <= '0;
      to_q <= 1'b0;
    end else if (wr_stb) begin
      tmr  <= '0;
    end else if (!has_data) begin
      tmr  <= '0;
      to_q <= 1'b0;
    end else if (!to_q && baud_en) begin
      if (tmr == limit - 1'b1) begin
        tmr  <= '0;
        to_q <= 1'b1;
      end else begin
        tmr  <= tmr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fifo_clr)  dr_q <= 1'b0;
    else if (wr_stb)         dr_q <= 1'b1;
    else if (!has_data)      dr_q <= 1'b0;
  end

  assign data_ready  = dr_q;
  assign rda_irq     = rx_on && has_data && (count >= trig_lvl);
  assign timeout_irq = rx_on && to_q;
  assign ls_irq      = fifo_en && ls_ie && ls_err;

  always_comb begin
    if (ls_irq)           irq_code = 4'h6;
    else if (timeout_irq) irq_code = 4'hC;
    else if (rda_irq)     irq_code = 4'h4;
    else                  irq_code = 4'h1;
  end
endmodule

module uart_rx_irq_chk #(
  parameter int TW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_clr,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic [4:0]    count,
  input logic          data_ready,
  input logic          timeout_irq,
  input logic          ls_irq,
  input logic [3:0]    irq_code,
  input logic          to_q,
  input logic [TW-1:0] tmr
);
  // R2
  dr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(wr_stb));
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !to_q && tmr == '0);
  // R8
  wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !to_q |=> tmr == '0);
  // R12
  empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 |=> !to_q);
  // R10
  fifo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> !data_ready && !to_q);
  // R4
  code_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_code == 4'hC |-> timeout_irq && !ls_irq);
endmodule

bind uart_rx_irq uart_rx_irq_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .wr_stb(wr_stb),
  .rd_stb(rd_stb), .count(count), .data_ready(data_ready),
  .timeout_irq(timeout_irq), .ls_irq(ls_irq), .irq_code(irq_code),
  .to_q(to_q), .tmr(tmr)
);

// File: tb/sim_uart_rx_irq.sv
module sim_uart_rx_irq;
  logic       clk = 1'b0;
  logic       rst_n, fifo_clr, fifo_en, rx_ie, ls_ie, wr_stb, rd_stb;
  logic [4:0] count, trig_lvl;
  logic       ls_err, baud_en, parity_en, two_stop;
  logic [1:0] data_bits;
  logic       data_ready, rda_irq, timeout_irq, ls_irq;
  logic [3:0] irq_code;
  int         errors = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  uart_rx_irq u0 (.*);

  // {count, trig, ls_err, rx_ie, ls_ie, exp_rda, exp_ls, exp_code}
  localparam logic [18:0] VEC [9] = '{
    {5'd0,  5'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h1},
    {5'd1,  5'd1,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'h4},
    {5'd3,  5'd4,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h1},
    {5'd4,  5'd4,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'h4},
    {5'd8,  5'd4,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'h6},
    {5'd8,  5'd4,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'h6},
    {5'd14, 5'd14, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h4},
    {5'd0,  5'd8,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'h6},
    {5'd16, 5'd14, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic run(input int n, input int div);
    for (int i = 0; i < n; i++) begin
      baud_en = (i % div) == div - 1;
      tick();
    end
  endtask

  task automatic push();
    wr_stb = 1'b1; tick(); wr_stb = 1'b0; count = count + 1'b1;
  endtask

  task automatic pop();
    rd_stb = 1'b1; tick(); rd_stb = 1'b0; count = count - 1'b1;
  endtask

  task automatic clear();
    fifo_clr = 1'b1; tick(); fifo_clr = 1'b0; count = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fifo_clr = 0; fifo_en = 1; rx_ie = 1; ls_ie = 1;
    wr_stb = 0; rd_stb = 0; count = 0; trig_lvl = 5'd8; ls_err = 0;
    baud_en = 0; data_bits = 2'd0; parity_en = 0; two_stop = 0;
    tick(); tick();
    rst_n = 1; #1;
    // R10 reset state
    chk("R10 dr", data_ready, 0);
    chk("R10 to", timeout_irq, 0);
    chk("R4 code idle", irq_code, 4'h1);

    // R1 R3 R4 R9 vector table
    foreach (VEC[i]) begin
      {count, trig_lvl, ls_err, rx_ie, ls_ie} = VEC[i][18:6];
      #1;
      chk("R1/R9 rda", rda_irq, VEC[i][5]);
      chk("R3 ls", ls_irq, VEC[i][4]);
      chk("R4 code", irq_code, VEC[i][3:0]);
    end
    count = 0; ls_err = 0; rx_ie = 1; ls_ie = 1; trig_lvl = 5'd8;
    tick(); tick();

    // R2 data ready
    push();
    chk("R2 set", data_ready, 1);
    pop();
    chk("R2 hold", data_ready, 1);
    tick();
    chk("R2 clear", data_ready, 0);

    // R5 R6 shortest frame: 7 bits, 448 enables
    baud_en = 1;
    push();
    run(447, 1);
    chk("R5 early", timeout_irq, 0);
    run(1, 1);
    chk("R5 fire", timeout_irq, 1);
    chk("R4 code C", irq_code, 4'hC);
    // R8 write does not clear pending
    push();
    chk("R8 pending kept", timeout_irq, 1);
    // R9 gating
    rx_ie = 0; #1;
    chk("R9 to gated", timeout_irq, 0);
    chk("R9 code gated", irq_code, 4'h1);
    rx_ie = 1; ls_err = 1; #1;
    chk("R4 ls over to", irq_code, 4'h6);
    ls_err = 0;
    // R7 read clears, timer restarts
    pop();
    chk("R7 clear", timeout_irq, 0);
    run(447, 1);
    chk("R7 restart early", timeout_irq, 0);
    run(1, 1);
    chk("R7 restart fire", timeout_irq, 1);
    // R10 fifo reset
    clear();
    chk("R10 to clr", timeout_irq, 0);
    chk("R10 dr clr", data_ready, 0);

    // R8 read and write restart timer part-way
    push(); push();
    run(300, 1);
    pop();
    run(447, 1);
    chk("R8 rd restart", timeout_irq, 0);
    run(1, 1);
    chk("R8 rd fire", timeout_irq, 1);
    clear();
    push();
    run(300, 1);
    push();
    run(447, 1);
    chk("R8 wr restart", timeout_irq, 0);
    run(1, 1);
    chk("R8 wr fire", timeout_irq, 1);
    clear();

    // R6 longest frame: 8 data, parity, 2 stop -> 12 bits, 768 enables
    data_bits = 2'd3; parity_en = 1; two_stop = 1;
    push();
    run(767, 1);
    chk("R6 long early", timeout_irq, 0);
    run(1, 1);
    chk("R6 long fire", timeout_irq, 1);
    clear();
    data_bits = 2'd0; parity_en = 0; two_stop = 0;

    // R11 enables every second cycle
    baud_en = 0;
    push();
    run(895, 2);
    chk("R11 slow early", timeout_irq, 0);
    baud_en = 1; tick();
    chk("R11 slow fire", timeout_irq, 1);

    // R12 empty fifo cannot time out
    pop();
    run(1000, 1);
    chk("R12 empty", timeout_irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule